// File: doc/BRIEF.md
# Interrupt Cascade Bus Steering

This block lets several interrupt controllers share one vectoring path over a 3-bit cascade bus. Each device works out its own role. When buffered operation is off, a strap pin decides it. When buffered operation is on, a configuration bit decides it and the strap pin is ignored.

A master receives the number of the input being serviced at the start of an acknowledge sequence. If that input has a slave attached, the master drives the number onto the cascade lines for the whole sequence. It then steps back from the data bus on the bytes that belong to the slave.

A slave compares the cascade lines with the ID held in the low bits of its slave register. It enables its data-bus output only on the bytes it owns, and only when the code matches.

A sequence is started by a one-cycle `ack_begin` pulse. Each `ack_next` pulse steps to the next byte.
- In 8-bit call mode there are three bytes: index 0, 1 and 2.
- In 16-bit mode there is a single vector byte: index 0.

The pulse on the last byte closes the sequence. Vector formation and priority resolution are handled elsewhere.

Top module: `cas_steer`

## Requirements
- R1: `is_master` equals `strap_master` when `buffered` is 0, and equals `cfg_master` when `buffered` is 1, whatever the strap pin holds.
- R2: Out of reset, and whenever no sequence is in progress (`seq_busy` 0), `cas_out` is 0 and both `cas_oe` and `data_oe` are 0.
- R3: A master acknowledging level L with `slave_map[L]`=1 drives `cas_out`=L with `cas_oe`=1 on every byte of the sequence. L is latched at `ack_begin`; later changes on `svc_level` are ignored.
- R4: A master acknowledging a level whose `slave_map` bit is 0 keeps `cas_out` at 0 and `cas_oe` at 0, and asserts `data_oe` on every byte.
- R5: A master with a cascaded level in 8-bit mode (`wide_cpu`=0) asserts `data_oe` on byte 0 only.
- R6: A master with a cascaded level in 16-bit mode (`wide_cpu`=1) never asserts `data_oe`.
- R7: A slave whose `cas_in` equals `slave_map[2:0]` asserts `data_oe` on bytes 1 and 2 in 8-bit mode and not on byte 0. Bits 7..3 of `slave_map` have no effect. A slave never asserts `cas_oe` and holds `cas_out` at 0.
- R8: A matching slave in 16-bit mode asserts `data_oe` on byte 0.
- R9: A slave whose `cas_in` differs from its ID keeps `data_oe` at 0 for the whole sequence.
- R10: `seq_busy` rises one cycle after `ack_begin`. It falls one cycle after the third `ack_next` in 8-bit mode, or after the first in 16-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_master | input | 1 | Role strap: 1 = master (used when not buffered) |
| buffered | input | 1 | Buffered operation: role comes from `cfg_master` |
| cfg_master | input | 1 | Role configuration bit: 1 = master |
| wide_cpu | input | 1 | 1 = 16-bit mode (one vector byte), 0 = 8-bit call mode (three bytes) |
| slave_map | input | NUM_IN | Master: one bit per input with a slave attached; slave: bits 2..0 are the ID |
| ack_begin | input | 1 | Pulse: start an acknowledge sequence, latch `svc_level` |
| ack_next | input | 1 | Pulse: advance to the next byte |
| svc_level | input | CAS_W | Number of the input being serviced |
| cas_in | input | CAS_W | Cascade lines as seen by a slave |
| is_master | output | 1 | Resolved role |
| seq_busy | output | 1 | Acknowledge sequence in progress |
| cas_out | output | CAS_W | Cascade code driven by a master |
| cas_oe | output | 1 | Cascade line drive enable |
| data_oe | output | 1 | This device drives the data bus for the current byte |

## Verification
The assertions assume four things about the inputs:
- Role, mode, slave map and cascade inputs stay constant for the length of an acknowledge sequence.
- `ack_begin` and `ack_next` are never raised in the same cycle.
- `ack_next` is only pulsed while a sequence is running.
- `ack_begin` is only pulsed while no sequence is running.

The stimulus meets these assumptions by design. It changes configuration only between sequences. It issues exactly one `ack_begin` followed by the number of `ack_next` pulses the mode requires. Each pulse lasts a single cycle, with idle cycles in between. The only input allowed to move mid-sequence is `svc_level`, which is deliberately disturbed to show that the latched level holds.

// File: rtl/cas_pkg.sv
package cas_pkg;

  localparam int CALL_BYTES = 3;
  localparam int WIDE_BYTES = 1;
  localparam int IDX_W      = 2;

  // Role resolution: configuration bit wins only when buffered.
  function automatic logic pick_master(input logic strap, input logic buffered,
                                       input logic cfg_bit);
    return buffered ? cfg_bit : strap;
  endfunction

  // Index of the final byte of a sequence for the given bus mode.
  function automatic logic [IDX_W-1:0] final_index(input logic wide);
    return wide ? IDX_W'(WIDE_BYTES - 1) : IDX_W'(CALL_BYTES - 1);
  endfunction

  // Master keeps a byte unless a slave owns it.
  function automatic logic master_keeps(input logic cascaded, input logic wide,
                                        input logic [IDX_W-1:0] idx);
    return !cascaded || (!wide && idx == '0);
  endfunction

  // Bytes a matched slave releases.
  function automatic logic slave_owns(input logic wide, input logic [IDX_W-1:0] idx);
    return wide ? (idx == '0) : (idx != '0);
  endfunction

endpackage

// File: rtl/cas_ack_seq.sv
module cas_ack_seq
  import cas_pkg::*;
#(
  parameter int CAS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide_cpu,
  input  logic             ack_begin,
  input  logic             ack_next,
  input  logic [CAS_W-1:0] svc_level,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic [CAS_W-1:0] level_q,
  output logic             last_byte
);

  assign last_byte = busy && (idx == final_index(wide_cpu));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      level_q <= '0;
    end else if (ack_begin) begin
      busy    <= 1'b1;
      idx     <= '0;
      level_q <= svc_level;
    end else if (ack_next && busy) begin
      if (last_byte) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cas_master_drive.sv
module cas_master_drive
  import cas_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int CAS_W  = $clog2(NUM_IN)
) (
  input  logic              busy,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wide_cpu,
  input  logic [CAS_W-1:0]  level_q,
  input  logic [NUM_IN-1:0] slave_map,
  output logic              cascaded,
  output logic [CAS_W-1:0]  code,
  output logic              own_byte
);

  assign cascaded = busy && slave_map[level_q];
  assign code     = cascaded ? level_q : '0;
  assign own_byte = busy && master_keeps(cascaded, wide_cpu, idx);

endmodule

// File: rtl/cas_slave_match.sv
module cas_slave_match
  import cas_pkg::*;
#(
  parameter int CAS_W = 3
) (
  input  logic             busy,
  input  logic [IDX_W-1:0] idx,
  input  logic             wide_cpu,
  input  logic [CAS_W-1:0] my_id,
  input  logic [CAS_W-1:0] cas_in,
  output logic             id_hit,
  output logic             own_byte
);

  assign id_hit   = busy && (cas_in == my_id);
  assign own_byte = id_hit && slave_owns(wide_cpu, idx);

endmodule

// File: rtl/cas_steer.sv
module cas_steer
  import cas_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int CAS_W  = $clog2(NUM_IN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_master,
  input  logic              buffered,
  input  logic              cfg_master,
  input  logic              wide_cpu,
  input  logic [NUM_IN-1:0] slave_map,
  input  logic              ack_begin,
  input  logic              ack_next,
  input  logic [CAS_W-1:0]  svc_level,
  input  logic [CAS_W-1:0]  cas_in,
  output logic              is_master,
  output logic              seq_busy,
  output logic [CAS_W-1:0]  cas_out,
  output logic              cas_oe,
  output logic              data_oe
);

  logic [IDX_W-1:0] byte_idx;
  logic [CAS_W-1:0] level_q;
  logic             last_byte;
  logic             m_cascaded;
  logic [CAS_W-1:0] m_code;
  logic             m_own;
  logic             s_hit;
  logic             s_own;

  assign is_master = pick_master(strap_master, buffered, cfg_master);

  cas_ack_seq #(.CAS_W(CAS_W)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wide_cpu  (wide_cpu),
    .ack_begin (ack_begin),
    .ack_next  (ack_next),
    .svc_level (svc_level),
    .busy      (seq_busy),
    .idx       (byte_idx),
    .level_q   (level_q),
    .last_byte (last_byte)
  );

  cas_master_drive #(.NUM_IN(NUM_IN), .CAS_W(CAS_W)) mst_i (
    .busy      (seq_busy),
    .idx       (byte_idx),
    .wide_cpu  (wide_cpu),
    .level_q   (level_q),
    .slave_map (slave_map),
    .cascaded  (m_cascaded),
    .code      (m_code),
    .own_byte  (m_own)
  );

  cas_slave_match #(.CAS_W(CAS_W)) slv_i (
    .busy     (seq_busy),
    .idx      (byte_idx),
    .wide_cpu (wide_cpu),
    .my_id    (slave_map[CAS_W-1:0]),
    .cas_in   (cas_in),
    .id_hit   (s_hit),
    .own_byte (s_own)
  );

  assign cas_oe  = is_master && m_cascaded;
  assign cas_out = is_master ? m_code : '0;
  assign data_oe = is_master ? m_own : s_own;

endmodule

// File: rtl/cas_steer_chk.sv
module cas_steer_chk #(
  parameter int NUM_IN = 8,
  parameter int CAS_W  = $clog2(NUM_IN)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              is_master,
  input logic              wide_cpu,
  input logic [NUM_IN-1:0] slave_map,
  input logic              ack_begin,
  input logic              ack_next,
  input logic [CAS_W-1:0]  cas_in,
  input logic              seq_busy,
  input logic              last_byte,
  input logic [CAS_W-1:0]  cas_out,
  input logic              cas_oe,
  input logic              data_oe
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy |-> (!data_oe && !cas_oe && cas_out == '0)); // R2

  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && $past(seq_busy) && !$past(ack_begin)) |-> $stable(cas_out)); // R3

  AST_WIDE_MASTER_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && wide_cpu && cas_oe) |-> !data_oe); // R6

  AST_SLAVE_NO_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> !cas_oe); // R7

  AST_SLAVE_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && seq_busy && cas_in != slave_map[CAS_W-1:0]) |-> !data_oe); // R9

  AST_SEQ_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && ack_next && !ack_begin) |=> !seq_busy); // R10

  AST_SEQ_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    ack_begin |=> seq_busy); // R10

endmodule

bind cas_steer cas_steer_chk #(.NUM_IN(NUM_IN), .CAS_W(CAS_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .is_master (is_master),
  .wide_cpu  (wide_cpu),
  .slave_map (slave_map),
  .ack_begin (ack_begin),
  .ack_next  (ack_next),
  .cas_in    (cas_in),
  .seq_busy  (seq_busy),
  .last_byte (last_byte),
  .cas_out   (cas_out),
  .cas_oe    (cas_oe),
  .data_oe   (data_oe)
);

// File: tb/cas_steer_tb.sv
`timescale 1ns/1ps
module cas_steer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       strap_master, buffered, cfg_master, wide_cpu;
  logic [7:0] slave_map;
  logic       ack_begin, ack_next;
  logic [2:0] svc_level, cas_in;
  logic       is_master, seq_busy, cas_oe, data_oe;
  logic [2:0] cas_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  cas_steer dut_i (
    .clk(clk), .rst_n(rst_n), .strap_master(strap_master), .buffered(buffered),
    .cfg_master(cfg_master), .wide_cpu(wide_cpu), .slave_map(slave_map),
    .ack_begin(ack_begin), .ack_next(ack_next), .svc_level(svc_level),
    .cas_in(cas_in), .is_master(is_master), .seq_busy(seq_busy),
    .cas_out(cas_out), .cas_oe(cas_oe), .data_oe(data_oe)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      finish_run();
    end
  end

  // Bundle of expected outputs, packed as {cas_oe, cas_out, data_oe}.
  function automatic int pack_out(input int coe, input int code, input int doe);
    return coe * 16 + code * 2 + doe;
  endfunction

  // Run one sequence; is_mst selects how expectations are formed.
  task automatic run_seq(input string req, input int lvl, input int wide, input int is_mst);
    int nbytes;
    int hooked;
    int id;
    nbytes = (wide != 0) ? 1 : 3;
    hooked = (slave_map >> lvl) & 1;
    id     = slave_map % 8;
    @(negedge clk);
    svc_level = 3'(lvl);
    ack_begin = 1'b1;
    @(negedge clk);
    ack_begin = 1'b0;
    svc_level = 3'(7 - lvl);               // must not disturb the latched level
    check({req, " R10 busy rise"}, int'(seq_busy), 1);
    for (int b = 0; b < nbytes; b++) begin
      int e_coe, e_code, e_doe;
      if (is_mst != 0) begin
        e_coe  = hooked;
        e_code = hooked * lvl;
        e_doe  = (hooked == 0) ? 1 : ((wide == 0 && b == 0) ? 1 : 0);
      end else begin
        e_coe  = 0;
        e_code = 0;
        e_doe  = (int'(cas_in) == id) ? ((wide != 0) ? int'(b == 0) : int'(b > 0)) : 0;
      end
      check(req, pack_out(int'(cas_oe), int'(cas_out), int'(data_oe)),
            pack_out(e_coe, e_code, e_doe));
      ack_next = 1'b1;
      @(negedge clk);
      ack_next = 1'b0;
    end
    check({req, " R10 busy fall"}, int'(seq_busy), 0);
    check({req, " R2 idle"}, pack_out(int'(cas_oe), int'(cas_out), int'(data_oe)), 0);
  endtask

  initial begin
    rst_n = 1'b0; strap_master = 1'b1; buffered = 1'b0; cfg_master = 1'b0;
    wide_cpu = 1'b0; slave_map = 8'h00; ack_begin = 1'b0; ack_next = 1'b0;
    svc_level = 3'd0; cas_in = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 reset", pack_out(int'(cas_oe), int'(cas_out), int'(data_oe)) + 32 * int'(seq_busy), 0);

    // R1: role from strap or configuration bit
    for (int k = 0; k < 8; k++) begin
      strap_master = k[0]; cfg_master = k[1]; buffered = k[2];
      #1;
      check("R1 role", int'(is_master), (k[2] != 0) ? int'(k[1]) : int'(k[0]));
    end

    // Master sweep: R3/R4/R5/R6
    strap_master = 1'b1; buffered = 1'b0;
    for (int w = 0; w < 2; w++) begin
      wide_cpu = w[0];
      for (int m = 0; m < 3; m++) begin
        slave_map = (m == 0) ? 8'hA5 : ((m == 1) ? 8'h5A : 8'h00);
        for (int lvl = 0; lvl < 8; lvl++)
          run_seq((w != 0) ? "R3 R4 R6 master" : "R3 R4 R5 master", lvl, w, 1);
      end
    end

    // Slave sweep: R7/R8/R9, role also via buffered cfg bit
    strap_master = 1'b1; buffered = 1'b1; cfg_master = 1'b0;
    for (int w = 0; w < 2; w++) begin
      wide_cpu = w[0];
      for (int id = 0; id < 8; id++) begin
        for (int c = 0; c < 8; c++) begin
          slave_map = 8'((id * 37 + c * 8) % 256);
          slave_map[2:0] = 3'(id);          // upper bits vary, must not matter
          cas_in = 3'(c);
          run_seq((w != 0) ? "R8 R9 slave" : "R7 R9 slave", 0, w, 0);
        end
      end
    end

    finish_run();
  end

endmodule